// File: doc/BRIEF.md
# Sound Coprocessor Address Decoder with Banked Main-Bus Window

This block sits between an 8-bit sound coprocessor's 16-bit address space and the targets that space reaches. Each request can be one byte or a 16-bit word, and a word is carried out as two byte operations. Every byte operation is sent to exactly one target, or it is flagged as unmapped. The targets are a local 8 KB RAM, an FM synthesizer port, a write-only PSG port, an internal bank register, and a 32 KB window into a 24-bit main-bus space. The RAM and the synthesizer are reached through the block's strobes and do not live inside it.

The upper nine bits of every window address come from the bank register. Software loads that register one bit at a time: each write to the bank page shifts a new bit in at the top. Requests enter through a valid/ready channel, and the read result leaves through a second valid/ready channel. While a read result has not been taken, `req_ready` stays low, so results always leave in request order and never overwrite each other. Write requests return no result.

Each byte operation produces one cycle of registered strobes. Read data from a target must be valid during the cycle in which its enable is high.

Top module: `snd_addr_decoder`

## Requirements
- R1: A byte operation at an address below 0x4000 raises `ram_en` for one cycle, with `ram_addr` equal to address bits 12:0. The RAM therefore appears twice in that range. A read returns `ram_rdata`.
- R2: A byte operation whose address bits 15:13 equal 3'b010 raises `fm_en`, with `fm_addr` equal to address bits 1:0. A write passes the data on `op_wdata`, and a read returns `fm_status`.
- R3: A write whose address ANDed with 0xFFF9 equals 0x7F11 raises `psg_en` with the data on `op_wdata`. A read of those addresses is unmapped.
- R4: A write whose address bits 15:8 equal 0x60 sets bank = {data bit 0, bank[8:1]} and raises no strobe. A read of that page leaves the bank unchanged.
- R5: A byte operation at address 0x8000 or above raises `main_en`, with `main_addr` = {bank, address bits 14:0}. This applies to reads and writes, and a read returns `main_rdata`.
- R6: A word request makes two byte operations in consecutive cycles. The low byte goes to address a with data bits 7:0. The high byte goes to a+1, wrapping at 16 bits, with data bits 15:8. A word read returns {high byte, low byte}. A byte read returns its byte in bits 7:0 and zero in bits 15:8.
- R7: Any other byte operation is unmapped. It raises no target strobe, it pulses `anomaly` for one cycle, and as a read it returns 0.
- R8: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low while a request is still being split and while a read result is waiting to be taken.
- R9: Once `rsp_valid` is high, it and `rsp_rdata` stay unchanged until an edge where `rsp_ready` is high.
- R10: After reset, all strobes, `anomaly` and `rsp_valid` are low, `req_ready` is high, and the bank is 0.
- R11: The strobe for the first byte appears in the second cycle after the accepting edge. `rsp_valid` rises in the cycle after the last byte's strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 16-bit access, 0 = byte |
| req_addr | input | 16 | Coprocessor address |
| req_wdata | input | 16 | Write data; bits 7:0 for byte writes |
| rsp_valid | output | 1 | Read result present |
| rsp_ready | input | 1 | Read result taken |
| rsp_rdata | output | 16 | Read result |
| op_we | output | 1 | Current byte operation is a write |
| op_wdata | output | 8 | Write byte for the current operation |
| ram_en | output | 1 | Local RAM strobe |
| ram_addr | output | 13 | Local RAM byte address |
| ram_rdata | input | 8 | Local RAM read byte |
| fm_en | output | 1 | FM synthesizer strobe |
| fm_addr | output | 2 | FM port select |
| fm_status | input | 8 | FM status byte |
| psg_en | output | 1 | PSG write strobe |
| main_en | output | 1 | Main-bus window strobe |
| main_addr | output | 24 | Main-bus byte address |
| main_rdata | input | 8 | Main-bus read byte |
| anomaly | output | 1 | Unmapped access pulse |

## Verification
The critical overlap is a byte operation that changes the bank, or that crosses into another region, in the same cycle as the byte next to it is decoded. One case is a word write at 0x5FFF, which hits the synthesizer and then shifts the bank; a later window access must then show the new bank. Other cases are word reads at 0x3FFF, 0x7FFF and 0xFFFF, each of which straddles two regions, one of them with a 16-bit wrap. A scoreboard predicts every strobe and every assembled result from a separate address-map and bank model. Result back-pressure is held while a read is waiting, to check that `req_ready` is blocked and that the result stays unchanged.

// File: rtl/snd_dec_pkg.sv
package snd_dec_pkg;
  localparam int CPU_AW = 16;
  localparam int BYTE_W = 8;

  localparam logic [2:0]        FM_SEG    = 3'b010;
  localparam logic [7:0]        BANK_PAGE = 8'h60;
  localparam logic [CPU_AW-1:0] PSG_MASK  = 16'hFFF9;
  localparam logic [CPU_AW-1:0] PSG_MATCH = 16'h7F11;

  typedef enum logic [2:0] {
    TGT_NONE, TGT_RAM, TGT_FM, TGT_PSG, TGT_BANK, TGT_MAIN
  } tgt_e;

  typedef struct packed {
    logic              vld;
    logic              we;
    logic              hi;
    logic              last;
    logic [CPU_AW-1:0] addr;
    logic [BYTE_W-1:0] data;
  } byte_op_t;
endpackage

// File: rtl/snd_byte_seq.sv
module snd_byte_seq
  import snd_dec_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic                req_wide,
  input  logic [CPU_AW-1:0]   req_addr,
  input  logic [2*BYTE_W-1:0] req_wdata,
  input  logic                rsp_done,
  output byte_op_t            op
);
  typedef enum logic [1:0] {S_IDLE, S_LO, S_HI} seq_e;

  seq_e                st;
  logic [CPU_AW-1:0]   a_q;
  logic [2*BYTE_W-1:0] d_q;
  logic                we_q, wide_q, pend_q;

  assign req_ready = (st == S_IDLE) && !pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      a_q    <= '0;
      d_q    <= '0;
      we_q   <= 1'b0;
      wide_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (rsp_done) pend_q <= 1'b0;
      unique case (st)
        S_IDLE: if (req_valid && req_ready) begin
          a_q    <= req_addr;
          d_q    <= req_wdata;
          we_q   <= req_write;
          wide_q <= req_wide;
          st     <= S_LO;
          if (!req_write) pend_q <= 1'b1;
        end
        S_LO:    st <= wide_q ? S_HI : S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    op.vld  = (st != S_IDLE);
    op.we   = we_q;
    op.hi   = (st == S_HI);
    op.last = (st == S_HI) || ((st == S_LO) && !wide_q);
    op.addr = (st == S_HI) ? a_q + CPU_AW'(1) : a_q;
    op.data = (st == S_HI) ? d_q[2*BYTE_W-1:BYTE_W] : d_q[BYTE_W-1:0];
  end

  // R6: the high byte targets the address after the low byte
  p_hi_next_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    op.hi |-> (op.addr == $past(op.addr) + CPU_AW'(1)));
endmodule

// File: rtl/snd_bank_reg.sv
module snd_bank_reg #(
  parameter int BANK_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift,
  input  logic              bit_in,
  output logic [BANK_W-1:0] bank
);
  always_ff @(posedge clk) begin
    if (!rst_n)     bank <= '0;
    else if (shift) bank <= {bit_in, bank[BANK_W-1:1]};
  end

  // R4: the bank changes only on a bank-page write
  p_bank_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !shift |=> $stable(bank));
endmodule

// File: rtl/snd_addr_map.sv
module snd_addr_map
  import snd_dec_pkg::*;
#(
  parameter int BANK_W  = 9,
  parameter int MAIN_AW = 24
) (
  input  logic [CPU_AW-1:0]  addr,
  input  logic               we,
  input  logic [BANK_W-1:0]  bank,
  output tgt_e               tgt,
  output logic [MAIN_AW-1:0] main_addr
);
  localparam int WIN_AW = MAIN_AW - BANK_W;

  assign main_addr = {bank, addr[WIN_AW-1:0]};

  always_comb begin
    if (addr[CPU_AW-1])
      tgt = TGT_MAIN;
    else if (addr[CPU_AW-1:CPU_AW-2] == 2'b00)
      tgt = TGT_RAM;
    else if (addr[CPU_AW-1:CPU_AW-3] == FM_SEG)
      tgt = TGT_FM;
    else if (we && addr[CPU_AW-1:CPU_AW-8] == BANK_PAGE)
      tgt = TGT_BANK;
    else if (we && (addr & PSG_MASK) == PSG_MATCH)
      tgt = TGT_PSG;
    else
      tgt = TGT_NONE;
  end
endmodule

// File: rtl/snd_rsp_pack.sv
module snd_rsp_pack
  import snd_dec_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                op_rd,
  input  logic                op_hi,
  input  logic                op_last,
  input  tgt_e                op_tgt,
  input  logic [BYTE_W-1:0]   ram_rdata,
  input  logic [BYTE_W-1:0]   fm_status,
  input  logic [BYTE_W-1:0]   main_rdata,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic [2*BYTE_W-1:0] rsp_rdata
);
  logic              tag_rd, tag_hi, tag_last;
  tgt_e              tag_tgt;
  logic [BYTE_W-1:0] sel;
  logic [BYTE_W-1:0] lane_q [2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tag_rd   <= 1'b0;
      tag_hi   <= 1'b0;
      tag_last <= 1'b0;
      tag_tgt  <= TGT_NONE;
    end else begin
      tag_rd   <= op_rd;
      tag_hi   <= op_hi;
      tag_last <= op_last;
      tag_tgt  <= op_tgt;
    end
  end

  always_comb begin
    unique case (tag_tgt)
      TGT_RAM:  sel = ram_rdata;
      TGT_FM:   sel = fm_status;
      TGT_MAIN: sel = main_rdata;
      default:  sel = '0;
    endcase
  end

  for (genvar g = 0; g < 2; g++) begin : g_lane
    localparam bit IS_HI = (g == 1);
    always_ff @(posedge clk) begin
      if (!rst_n)
        lane_q[g] <= '0;
      else if (tag_rd && (tag_hi == IS_HI))
        lane_q[g] <= sel;
      else if (tag_rd && !tag_hi && IS_HI)
        lane_q[g] <= '0;
    end
  end

  assign rsp_rdata = {lane_q[1], lane_q[0]};

  always_ff @(posedge clk) begin
    if (!rst_n)
      rsp_valid <= 1'b0;
    else if (tag_rd && tag_last)
      rsp_valid <= 1'b1;
    else if (rsp_ready)
      rsp_valid <= 1'b0;
  end

  // R9: a waiting result holds still
  p_rsp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));
endmodule

// File: rtl/snd_addr_decoder.sv
module snd_addr_decoder
  import snd_dec_pkg::*;
#(
  parameter int RAM_AW  = 13,
  parameter int FM_AW   = 2,
  parameter int BANK_W  = 9,
  parameter int MAIN_AW = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic                req_wide,
  input  logic [CPU_AW-1:0]   req_addr,
  input  logic [2*BYTE_W-1:0] req_wdata,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic [2*BYTE_W-1:0] rsp_rdata,
  output logic                op_we,
  output logic [BYTE_W-1:0]   op_wdata,
  output logic                ram_en,
  output logic [RAM_AW-1:0]   ram_addr,
  input  logic [BYTE_W-1:0]   ram_rdata,
  output logic                fm_en,
  output logic [FM_AW-1:0]    fm_addr,
  input  logic [BYTE_W-1:0]   fm_status,
  output logic                psg_en,
  output logic                main_en,
  output logic [MAIN_AW-1:0]  main_addr,
  input  logic [BYTE_W-1:0]   main_rdata,
  output logic                anomaly
);
  byte_op_t           op;
  tgt_e               tgt;
  logic [BANK_W-1:0]  bank;
  logic [MAIN_AW-1:0] win_addr;
  logic               rsp_done;

  assign rsp_done = rsp_valid && rsp_ready;

  snd_byte_seq u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_wide(req_wide), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_done(rsp_done), .op(op)
  );

  snd_addr_map #(.BANK_W(BANK_W), .MAIN_AW(MAIN_AW)) u_map (
    .addr(op.addr), .we(op.we), .bank(bank), .tgt(tgt), .main_addr(win_addr)
  );

  snd_bank_reg #(.BANK_W(BANK_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .shift(op.vld && tgt == TGT_BANK),
    .bit_in(op.data[0]), .bank(bank)
  );

  snd_rsp_pack u_rsp (
    .clk(clk), .rst_n(rst_n), .op_rd(op.vld && !op.we), .op_hi(op.hi),
    .op_last(op.last), .op_tgt(tgt), .ram_rdata(ram_rdata),
    .fm_status(fm_status), .main_rdata(main_rdata), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ram_en    <= 1'b0;
      fm_en     <= 1'b0;
      psg_en    <= 1'b0;
      main_en   <= 1'b0;
      anomaly   <= 1'b0;
      op_we     <= 1'b0;
      op_wdata  <= '0;
      ram_addr  <= '0;
      fm_addr   <= '0;
      main_addr <= '0;
    end else begin
      ram_en    <= op.vld && tgt == TGT_RAM;
      fm_en     <= op.vld && tgt == TGT_FM;
      psg_en    <= op.vld && tgt == TGT_PSG;
      main_en   <= op.vld && tgt == TGT_MAIN;
      anomaly   <= op.vld && tgt == TGT_NONE;
      op_we     <= op.vld && op.we;
      op_wdata  <= op.data;
      ram_addr  <= op.addr[RAM_AW-1:0];
      fm_addr   <= op.addr[FM_AW-1:0];
      main_addr <= win_addr;
    end
  end

  // R5: window strobe carries the bank in force
  p_window_bank_r5: assert property (@(posedge clk) disable iff (!rst_n)
    main_en |-> (main_addr[MAIN_AW-1:MAIN_AW-BANK_W] == bank));
  // R3: the PSG port only ever sees writes
  p_psg_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    psg_en |-> op_we);
  // R7: at most one target or the anomaly flag per cycle
  p_one_target_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ram_en, fm_en, psg_en, main_en, anomaly}));
  // R8: no new request while a result waits
  p_ready_blocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);
endmodule

// File: tb/tb_snd_addr_decoder.sv
`timescale 1ns/1ps
module tb_snd_addr_decoder;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n, req_valid, req_ready, req_write, req_wide;
  logic [15:0] req_addr, req_wdata, rsp_rdata;
  logic        rsp_valid, rsp_ready, op_we, ram_en, fm_en, psg_en, main_en, anomaly;
  logic [7:0]  op_wdata, ram_rdata, fm_status, main_rdata;
  logic [12:0] ram_addr;
  logic [1:0]  fm_addr;
  logic [23:0] main_addr;

  snd_addr_decoder dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_wide(req_wide), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_rdata(rsp_rdata), .op_we(op_we), .op_wdata(op_wdata),
    .ram_en(ram_en), .ram_addr(ram_addr), .ram_rdata(ram_rdata),
    .fm_en(fm_en), .fm_addr(fm_addr), .fm_status(fm_status),
    .psg_en(psg_en), .main_en(main_en), .main_addr(main_addr),
    .main_rdata(main_rdata), .anomaly(anomaly)
  );

  // target models: read bytes derived from the address
  assign ram_rdata  = ram_addr[7:0] ^ 8'hA5;
  assign fm_status  = 8'h81;
  assign main_rdata = main_addr[7:0] ^ main_addr[22:15];

  typedef struct { int kind; bit we; int addr; int data; } ev_t;
  ev_t evq[$];
  int  rspq[$];
  int  checks = 0, fails = 0;
  bit  done = 0;
  logic [8:0] bm = '0;

  task automatic chk(input string tag, input int act, input int exp_v);
    checks++;
    if (act != exp_v) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp_v);
    end
  endtask

  function automatic string rq(input int k);
    case (k)
      1: return "R1 ram";
      2: return "R2 fm";
      3: return "R3 psg";
      5: return "R5 window";
      default: return "R7 unmapped";
    endcase
  endfunction

  // 0 none, 1 ram, 2 fm, 3 psg, 4 bank, 5 window
  function automatic int kind_of(input logic [15:0] a, input bit we);
    if (a[15]) return 5;
    if (a[15:14] == 2'b00) return 1;
    if (a[15:13] == 3'b010) return 2;
    if (we && a[15:8] == 8'h60) return 4;
    if (we && (a & 16'hFFF9) == 16'h7F11) return 3;
    return 0;
  endfunction

  task automatic predict(input bit we, input bit wide, input logic [15:0] a,
                         input logic [15:0] d);
    int rsp = 0;
    for (int i = 0; i < (wide ? 2 : 1); i++) begin
      logic [15:0] ba;
      logic [7:0]  bd;
      int k, rb;
      ev_t e;
      ba = a + 16'(i);
      bd = (i == 1) ? d[15:8] : d[7:0];
      k = kind_of(ba, we);
      rb = 0;
      e.kind = k; e.we = we; e.data = int'(bd); e.addr = 0;
      case (k)
        1: begin e.addr = int'(ba[12:0]); rb = int'(ba[7:0] ^ 8'hA5); end
        2: begin e.addr = int'(ba[1:0]);  rb = 8'h81; end
        5: begin e.addr = int'({bm, ba[14:0]}); rb = int'(ba[7:0] ^ bm[7:0]); end
        4: bm = {bd[0], bm[8:1]};
        default: ;
      endcase
      if (k != 4) evq.push_back(e);
      rsp |= rb << (8 * i);
    end
    if (!we) rspq.push_back(rsp);
  endtask

  // called at a negedge; returns at the negedge after acceptance
  task automatic send(input bit we, input bit wide, input logic [15:0] a,
                      input logic [15:0] d);
    predict(we, wide, a, d);
    req_valid = 1'b1; req_write = we; req_wide = wide; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // scoreboard monitor
  always begin
    @(negedge clk); #1;
    if (rst_n && !done) begin
      if (ram_en || fm_en || psg_en || main_en || anomaly) begin
        int k, ad;
        k = 0; ad = 0;
        if (ram_en)       begin k = 1; ad = int'(ram_addr); end
        else if (fm_en)   begin k = 2; ad = int'(fm_addr); end
        else if (psg_en)  k = 3;
        else if (main_en) begin k = 5; ad = int'(main_addr); end
        if (evq.size() == 0) chk("R7 unexpected strobe", k, -1);
        else begin
          ev_t e;
          e = evq.pop_front();
          chk({rq(e.kind), " target"}, k, e.kind);
          chk({rq(e.kind), " direction"}, int'(op_we), int'(e.we));
          chk({rq(e.kind), " address"}, ad, e.addr);
          if (e.we && e.kind != 0) chk({rq(e.kind), " data"}, int'(op_wdata), e.data);
        end
      end
      if (rsp_valid && rsp_ready) begin
        if (rspq.size() == 0) chk("R6 unexpected result", 1, 0);
        else chk("R6 read result", int'(rsp_rdata), rspq.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; req_valid = 0; req_write = 0; req_wide = 0;
    req_addr = '0; req_wdata = '0; rsp_ready = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R10 ready after reset", int'(req_ready), 1);
    chk("R10 rsp_valid after reset", int'(rsp_valid), 0);
    chk("R10 strobes after reset",
        int'({ram_en, fm_en, psg_en, main_en, anomaly}), 0);

    // R10: bank zero right after reset, seen through a window read
    send(0, 0, 16'h8123, 0);
    repeat (3) @(negedge clk);

    // R11 latency on a byte read of RAM
    predict(0, 0, 16'h0123, 0);
    req_valid = 1; req_write = 0; req_wide = 0; req_addr = 16'h0123;
    chk("R8 ready when idle", int'(req_ready), 1);
    @(negedge clk); req_valid = 0;
    chk("R11 no strobe in first cycle", int'(ram_en), 0);
    chk("R8 ready low while splitting", int'(req_ready), 0);
    @(negedge clk);
    chk("R11 strobe in second cycle", int'(ram_en), 1);
    @(negedge clk);
    chk("R11 result cycle after strobe", int'(rsp_valid), 1);
    @(negedge clk);

    // R1 RAM write and mirrored read
    send(1, 0, 16'h1ABC, 16'h005E);
    send(0, 0, 16'h3ABC, 0);
    // R2 FM write and status read
    send(1, 0, 16'h4003, 16'h0042);
    send(0, 0, 16'h5FFE, 0);
    // R3 PSG writes, near miss, read
    send(1, 0, 16'h7F11, 16'h0090);
    send(1, 0, 16'h7F17, 16'h009F);
    send(1, 0, 16'h7F19, 16'h0011);
    send(0, 0, 16'h7F13, 0);
    // R4 bank load with nine writes, then a read of the bank page
    for (int i = 0; i < 9; i++) send(1, 0, 16'h6000 + 16'(i), 16'((9'h1A5 >> i) & 1));
    send(0, 0, 16'h6000, 0);
    // R5 window read and write
    send(0, 0, 16'h8000, 0);
    send(1, 0, 16'hFFFF, 16'h00C3);
    // R6 word accesses across region edges
    send(0, 1, 16'h3FFF, 0);
    send(0, 1, 16'h7FFF, 0);
    send(0, 1, 16'hFFFF, 0);
    send(1, 1, 16'h5FFF, 16'h0177);
    send(0, 1, 16'h9002, 0);
    send(1, 1, 16'h0200, 16'hBEEF);
    // R7 unmapped write to the space between PSG and bank page
    send(1, 0, 16'h7000, 16'h0055);
    repeat (3) @(negedge clk);

    // R8 / R9 result back-pressure
    rsp_ready = 0;
    send(0, 1, 16'h8010, 0);
    repeat (4) @(negedge clk);
    chk("R9 result waiting", int'(rsp_valid), 1);
    chk("R8 ready blocked by result", int'(req_ready), 0);
    begin
      int held;
      held = int'(rsp_rdata);
      @(negedge clk);
      chk("R9 result stable", int'(rsp_rdata), held);
    end
    rsp_ready = 1;
    @(negedge clk);
    chk("R9 result released", int'(rsp_valid), 0);
    send(0, 0, 16'h8001, 0);

    repeat (8) @(negedge clk);
    chk("R6 scoreboard drained", evq.size() + rspq.size(), 0);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule